// File: doc/BRIEF.md
# Audio Controller Power-State Wake Logic

This block holds the power-management and wake-event logic of a link controller that serves an audio function and a modem function over three codec serial data-in lines. Each function has its own two-state power field: D0 for full operation and D3 for low power. While a function is in D3, the host cannot reach its status and enable registers, and it cannot raise the shared interrupt. A resume event on a data-in line can only request a wake, which it does on a separate active-low line.

Each data-in line passes through a synchronizer. A rising level seen while the link is idle counts as a resume event. A function in D0 records the event in its per-line status bit. A function in D3 with its wake enable set records the event in its wake status bit. When software writes a function from D3 back to D0, a one-cycle internal reset clears that function's status and enable state. An edge-detected pending flag makes sure that only new status edges after the transition raise the interrupt.

Top module: `aud_pm_wake`

## Requirements
- R1: After reset every register reads 0, both functions are in D0, irq_o is 0, wake_no is 1 and ack_o is 0.
- R2: A request held for one cycle gives ack_o in the next cycle, together with registered rdata_o. Address bit 2 selects the function (0 audio, 1 modem) and bits 1:0 select the register. Register 0 is power, with bit 0 set meaning D3. Register 1 is status: bits 2:0 are the resume lines and bit 3 is GPIO, modem only. Register 2 is enable, with the same layout. Register 3 is wake: bit 0 is wake status, bit 1 is wake enable, and bit 2 is the read-only OR of both functions' wake status. A write returns rdata_o = 0.
- R3: Any access to the status or enable register of a function in D3 returns err_o = 1 and rdata_o = 0. The power and wake registers answer in both states.
- R4: irq_o is the OR of the two functions' interrupts. A function in D3 contributes nothing, starting in the first cycle after the write that puts it in D3.
- R5: A rising edge on sdin_i[i] while link_idle_i is 1 is a resume event. It sets status bit i of every function in D0 on the third rising clock edge after the input changes. A falling edge does not produce an event, and neither does a rise while link_idle_i is 0.
- R6: A resume event sets a function's wake status only when that function is in D3 and its wake enable is 1.
- R7: A gpio_chg_i pulse sets modem status bit 3 when the modem is in D0. When the modem is in D3 with its wake enable set, the pulse sets modem wake status. The audio function ignores the pulse.
- R8: wake_no is 0 exactly when some function is in D3 with both its wake status and its wake enable set.
- R9: Writing power bit 0 = 0 to a function in D3 causes a one-cycle internal reset of that function. The reset clears the function's status and enable registers and keeps its wake status and wake enable.
- R10: irq_o rises one cycle after an enabled status bit is set, or one cycle after the enable is set for a status bit that is already set. It falls one cycle after the last enabled status bit is cleared.
- R11: Status bits and wake status clear when 1 is written to them. Writing 0 leaves them unchanged.
- R12: After a D3-to-D0 transition, events seen during D3 raise no interrupt. Only status bits set after the transition can raise one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdin_i | input | N_LINES | Codec serial data-in lines (asynchronous) |
| link_idle_i | input | 1 | Link idle qualifier for resume detection |
| gpio_chg_i | input | 1 | One-cycle GPIO status change pulse |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write enable |
| addr_i | input | 3 | Function select (bit 2) and register select (bits 1:0) |
| wdata_i | input | 8 | Host write data |
| ack_o | output | 1 | Access response valid, one cycle after request |
| err_o | output | 1 | Access aborted because the function is in D3 |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Shared level interrupt |
| wake_no | output | 1 | Wake request, active low |

## Verification
If a power field is stuck or flipped, it shows within one access as a wrong err_o on status reads. It also shows as wake_no and irq_o taking the opposite value on the cycle after the next resume event. A pending flag or edge history that is not cleared by the internal reset shows as irq_o staying high right after a D3-to-D0 write. A lost synchronizer stage moves the status set and the interrupt rise by one cycle, which the exact-cycle samples of irq_o catch.

// File: rtl/aud_pm_pkg.sv
package aud_pm_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_FN   = 2;
  localparam int unsigned FN_AUDIO = 0;
  localparam int unsigned FN_MODEM = 1;
  localparam int unsigned FN_W     = $clog2(NUM_FN);
  localparam int unsigned REG_W    = 2;
  localparam int unsigned ADDR_W   = FN_W + REG_W;

  typedef enum logic [REG_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STS  = 2'd1,
    REG_IEN  = 2'd2,
    REG_WAKE = 2'd3
  } reg_sel_e;

  function automatic logic reg_gated(reg_sel_e s);
    return (s == REG_STS) || (s == REG_IEN);
  endfunction
endpackage

// File: rtl/aud_pm_resume_det.sv
module aud_pm_resume_det #(
  parameter int unsigned N_LINES     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] sdin_i,
  input  logic               idle_i,
  output logic [N_LINES-1:0] evt_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        hist_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], sdin_i[g]};
        hist_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign evt_o[g] = sync_q[SYNC_STAGES-1] & ~hist_q & idle_i;

    p_evt_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o[g] |=> !evt_o[g]);
  end
endmodule

// File: rtl/aud_pm_func.sv
module aud_pm_func #(
  parameter int unsigned N_LINES  = 3,
  parameter bit          HAS_GPIO = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LINES-1:0]       evt_i,
  input  logic                     gpio_chg_i,
  input  logic                     wr_i,
  input  aud_pm_pkg::reg_sel_e     sel_i,
  input  logic [N_LINES:0]         wdata_i,
  input  logic                     any_wake_i,
  output logic [aud_pm_pkg::DATA_W-1:0] rdata_o,
  output logic                     d3_o,
  output logic                     irq_o,
  output logic                     wake_req_o,
  output logic                     wake_sts_o
);
  import aud_pm_pkg::*;

  logic               d3_q, srst_q;
  logic [N_LINES-1:0] rsts_q, rien_q, rsts_d;
  logic               gsts_q, gien_q, gsts_d;
  logic               wsts_q, wen_q, wsts_set;
  logic               cause, cause_q, pend_q;
  logic               wr_ctrl, wr_sts, wr_ien, wr_wake;
  logic               leave_d3, gpio_evt, any_evt;

  assign wr_ctrl  = wr_i && (sel_i == REG_CTRL);
  assign wr_sts   = wr_i && (sel_i == REG_STS);
  assign wr_ien   = wr_i && (sel_i == REG_IEN);
  assign wr_wake  = wr_i && (sel_i == REG_WAKE);
  assign leave_d3 = wr_ctrl & d3_q & ~wdata_i[0];
  assign gpio_evt = HAS_GPIO & gpio_chg_i;
  assign any_evt  = |evt_i;

  // events only land in status while in D0; W1C clear loses to a same-cycle set
  assign rsts_d   = (rsts_q & ~({N_LINES{wr_sts}} & wdata_i[N_LINES-1:0]))
                  | (evt_i & {N_LINES{~d3_q}});
  assign gsts_d   = HAS_GPIO ? ((gsts_q & ~(wr_sts & wdata_i[N_LINES])) | (gpio_evt & ~d3_q))
                             : 1'b0;
  assign wsts_set = d3_q & wen_q & (any_evt | gpio_evt);
  assign cause    = (|(rsts_q & rien_q)) | (gsts_q & gien_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d3_q    <= 1'b0;
      srst_q  <= 1'b0;
      wsts_q  <= 1'b0;
      wen_q   <= 1'b0;
      rsts_q  <= '0;
      rien_q  <= '0;
      gsts_q  <= 1'b0;
      gien_q  <= 1'b0;
      cause_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      srst_q <= leave_d3;
      if (wr_ctrl) d3_q <= wdata_i[0];
      wsts_q <= (wsts_q & ~(wr_wake & wdata_i[0])) | wsts_set;
      if (wr_wake) wen_q <= wdata_i[1];
      if (srst_q) begin
        rsts_q  <= '0;
        rien_q  <= '0;
        gsts_q  <= 1'b0;
        gien_q  <= 1'b0;
        cause_q <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        rsts_q <= rsts_d;
        gsts_q <= gsts_d;
        if (wr_ien) begin
          rien_q <= wdata_i[N_LINES-1:0];
          gien_q <= HAS_GPIO & wdata_i[N_LINES];
        end
        cause_q <= cause;
        // pending only on a fresh rise of the enabled cause
        if (d3_q || !cause) pend_q <= 1'b0;
        else if (!cause_q)  pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      REG_CTRL: rdata_o[0] = d3_q;
      REG_STS: begin
        rdata_o[N_LINES-1:0] = rsts_q;
        rdata_o[N_LINES]     = gsts_q;
      end
      REG_IEN: begin
        rdata_o[N_LINES-1:0] = rien_q;
        rdata_o[N_LINES]     = gien_q;
      end
      REG_WAKE: begin
        rdata_o[0] = wsts_q;
        rdata_o[1] = wen_q;
        rdata_o[2] = any_wake_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign d3_o       = d3_q;
  assign irq_o      = pend_q & ~d3_q;
  assign wake_req_o = wsts_q & wen_q & d3_q;
  assign wake_sts_o = wsts_q;

  p_irq_quiet_d3_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d3_o |-> !irq_o);
  p_srst_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q);
  p_srst_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (rsts_q == '0 && rien_q == '0 && !pend_q));
  p_srst_keeps_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && !wr_i) |=> ($stable(wen_q) && $stable(wsts_q)));
  p_status_only_d0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rsts_q & ~$past(rsts_q)) != '0) |-> !$past(d3_q));
  p_wake_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wsts_q) |-> ($past(wen_q) && $past(d3_q)));
endmodule

// File: rtl/aud_pm_wake.sv
module aud_pm_wake #(
  parameter int unsigned N_LINES = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] sdin_i,
  input  logic               link_idle_i,
  input  logic               gpio_chg_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic               ack_o,
  output logic               err_o,
  output logic [7:0]         rdata_o,
  output logic               irq_o,
  output logic               wake_no
);
  import aud_pm_pkg::*;

  logic [N_LINES-1:0] evt;
  logic [NUM_FN-1:0]  fn_d3, fn_irq, fn_wreq, fn_wsts, fn_wr;
  logic [DATA_W-1:0]  fn_rd [NUM_FN];
  logic [FN_W-1:0]    fn_sel;
  reg_sel_e           sel;
  logic               acc_err, any_wake;
  logic               ack_q, err_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               unused_wdata;

  assign fn_sel       = addr_i[ADDR_W-1:REG_W];
  assign sel          = reg_sel_e'(addr_i[REG_W-1:0]);
  assign acc_err      = fn_d3[fn_sel] & reg_gated(sel);
  assign any_wake     = |fn_wsts;
  assign unused_wdata = ^wdata_i[DATA_W-1:N_LINES+1];

  aud_pm_resume_det #(.N_LINES(N_LINES), .SYNC_STAGES(2)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdin_i (sdin_i),
    .idle_i (link_idle_i),
    .evt_o  (evt)
  );

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    assign fn_wr[f] = req_i & we_i & (fn_sel == FN_W'(f)) & ~acc_err;

    aud_pm_func #(.N_LINES(N_LINES), .HAS_GPIO(f == FN_MODEM)) u_fn (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt),
      .gpio_chg_i (gpio_chg_i),
      .wr_i       (fn_wr[f]),
      .sel_i      (sel),
      .wdata_i    (wdata_i[N_LINES:0]),
      .any_wake_i (any_wake),
      .rdata_o    (fn_rd[f]),
      .d3_o       (fn_d3[f]),
      .irq_o      (fn_irq[f]),
      .wake_req_o (fn_wreq[f]),
      .wake_sts_o (fn_wsts[f])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      err_q   <= req_i & acc_err;
      rdata_q <= (req_i & ~we_i & ~acc_err) ? fn_rd[fn_sel] : '0;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
  assign irq_o   = |fn_irq;
  assign wake_no = ~|fn_wreq;

  p_ack_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  p_err_zero_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0 && ack_o));
  p_wake_line_needs_d3_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_no |-> (fn_d3 != '0));
  p_irq_needs_d0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (fn_d3 != '1));
endmodule

// File: tb/test_aud_pm_wake.sv
`timescale 1ns/1ps
module test_aud_pm_wake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sdin = '0;
  logic       idle = 1'b1;
  logic       gpio = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack, err, irq, wake_n;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  int rd;
  bit er;

  always #2.5 clk = ~clk;

  aud_pm_wake #(.N_LINES(3)) i_aud_pm_wake (
    .clk_i(clk), .rst_ni(rst_n), .sdin_i(sdin), .link_idle_i(idle), .gpio_chg_i(gpio),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .err_o(err), .rdata_o(rdata), .irq_o(irq), .wake_no(wake_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sdin = '0; idle = 1'b1; gpio = 1'b0; req = 1'b0; we = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic bus(input bit w, input int fn, input int rg, input int wd,
                     output int r, output bit e);
    @(posedge clk); #1;
    req = 1'b1; we = w; addr = 3'((fn << 2) | rg); wdata = 8'(wd);
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    r = int'(rdata); e = err;
    chk("R2 ack", int'(ack), 1);
  endtask

  task automatic wr(input int fn, input int rg, input int wd);
    int r; bit e;
    bus(1'b1, fn, rg, wd, r, e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1 reset values
    do_reset();
    #1;
    chk("R1 irq", int'(irq), 0);
    chk("R1 wake_n", int'(wake_n), 1);
    chk("R1 ack", int'(ack), 0);
    for (int f = 0; f < 2; f++)
      for (int g = 0; g < 4; g++) begin
        bus(1'b0, f, g, 0, rd, er);
        chk("R1 reg zero", rd, 0);
        chk("R1 no err", int'(er), 0);
      end

    // R5: no event while link busy, no event on falling edge
    idle = 1'b0;
    @(posedge clk); #1 sdin[1] = 1'b1;
    cyc(5);
    idle = 1'b1;
    cyc(3);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R5 busy rise ignored", rd, 0);
    sdin[1] = 1'b0;
    cyc(5);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R5 fall ignored", rd, 0);

    // R10/R11: W1C and interrupt timing on audio
    wr(0, 2, 1);
    @(posedge clk); #1 sdin[0] = 1'b1; sdin[2] = 1'b1;
    cyc(3);
    chk("R5 set on third edge", int'(irq), 0);
    cyc(1);
    chk("R10 irq rise", int'(irq), 1);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R5 status lines", rd, 5);
    wr(0, 1, 0);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R11 write zero keeps", rd, 5);
    wr(0, 1, 4);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R11 clear bit2", rd, 1);
    chk("R10 irq held", int'(irq), 1);
    wr(0, 1, 1);
    chk("R10 irq still high one cycle", int'(irq), 1);
    cyc(1);
    chk("R10 irq fall", int'(irq), 0);
    sdin = '0;
    cyc(4);
    @(posedge clk); #1 sdin[2] = 1'b1;
    cyc(4);
    chk("R10 disabled status quiet", int'(irq), 0);
    wr(0, 2, 4);
    chk("R10 enable late not yet", int'(irq), 0);
    cyc(1);
    chk("R10 enable late irq", int'(irq), 1);
    // R4: entering D3 gates interrupt at once
    wr(0, 0, 1);
    chk("R4 irq gated in D3", int'(irq), 0);
    bus(1'b1, 0, 1, 4, rd, er);
    chk("R3 write err", int'(er), 1);
    bus(1'b0, 0, 2, 0, rd, er);
    chk("R3 read err", int'(er), 1);
    chk("R3 read data zero", rd, 0);
    bus(1'b0, 0, 0, 0, rd, er);
    chk("R3 power reg open", rd, 1);
    chk("R3 power reg no err", int'(er), 0);
    wr(0, 0, 0);
    cyc(2);
    chk("R12 no irq after leave", int'(irq), 0);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R9 status cleared", rd, 0);
    sdin = '0;

    // R7: GPIO
    do_reset();
    wr(1, 2, 8);
    @(posedge clk); #1 gpio = 1'b1;
    @(posedge clk); #1 gpio = 1'b0;
    bus(1'b0, 1, 1, 0, rd, er);
    chk("R7 modem gpio status", rd, 8);
    bus(1'b0, 0, 1, 0, rd, er);
    chk("R7 audio ignores gpio", rd, 0);
    chk("R7 gpio irq", int'(irq), 1);
    wr(1, 1, 8);
    wr(1, 3, 2);
    wr(1, 0, 1);
    @(posedge clk); #1 gpio = 1'b1;
    @(posedge clk); #1 gpio = 1'b0;
    chk("R8 gpio wake line", int'(wake_n), 0);
    bus(1'b0, 1, 3, 0, rd, er);
    chk("R7 gpio wake status", rd, 7);
    bus(1'b0, 0, 3, 0, rd, er);
    chk("R6 combined seen by audio", rd, 4);
    bus(1'b1, 1, 3, 3, rd, er);
    chk("R11 wake clear", int'(wake_n), 1);
    bus(1'b0, 1, 3, 0, rd, er);
    chk("R11 wake status cleared", rd, 2);
    wr(1, 3, 0);
    @(posedge clk); #1 gpio = 1'b1;
    @(posedge clk); #1 gpio = 1'b0;
    bus(1'b0, 1, 3, 0, rd, er);
    chk("R7 no wake without enable", rd, 0);

    // sweep: power states x wake enables x line
    for (int ad = 0; ad < 2; ad++)
      for (int md = 0; md < 2; md++)
        for (int wa = 0; wa < 2; wa++)
          for (int wm = 0; wm < 2; wm++)
            for (int ln = 0; ln < 3; ln++) begin
              int d3s[2], wen[2], ws[2], anyw, exp_irq;
              d3s[0] = ad; d3s[1] = md; wen[0] = wa; wen[1] = wm;
              do_reset();
              for (int f = 0; f < 2; f++) begin
                wr(f, 3, wen[f] << 1);
                wr(f, 2, 15);
                wr(f, 0, d3s[f]);
              end
              @(posedge clk); #1 sdin[ln] = 1'b1;
              cyc(3);
              chk("R10 irq not before status", int'(irq), 0);
              cyc(1);
              exp_irq = (ad == 0 || md == 0) ? 1 : 0;
              chk("R4 irq vs power state", int'(irq), exp_irq);
              for (int f = 0; f < 2; f++) ws[f] = d3s[f] & wen[f];
              anyw = ws[0] | ws[1];
              chk("R8 wake line", int'(wake_n), anyw ? 0 : 1);
              sdin = '0;
              for (int f = 0; f < 2; f++) begin
                bus(1'b0, f, 1, 0, rd, er);
                if (d3s[f] != 0) begin
                  chk("R3 status err in D3", int'(er), 1);
                  chk("R3 status data in D3", rd, 0);
                end else begin
                  chk("R5 status line bit", rd, 1 << ln);
                end
                bus(1'b0, f, 3, 0, rd, er);
                chk("R6 wake register", rd, ws[f] | (wen[f] << 1) | (anyw << 2));
              end
              for (int f = 0; f < 2; f++)
                if (d3s[f] != 0) begin
                  wr(f, 0, 0);
                  bus(1'b0, f, 3, 0, rd, er);
                  chk("R9 wake kept", rd, ws[f] | (wen[f] << 1) | (anyw << 2));
                  bus(1'b0, f, 2, 0, rd, er);
                  chk("R9 enable cleared", rd, 0);
                end
              cyc(1);
              chk("R12 irq after leave", int'(irq), exp_irq);
              chk("R8 wake line after leave", int'(wake_n), 1);
            end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule